// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic core of a small 8-bit datapath. It holds an accumulator and a status byte. One operand is always the accumulator. The other operand comes from a hidden temporary register upstream, which reaches this block on `tmp_opnd`. A three-bit operation code selects one of eight functions: add, add with carry, subtract, subtract with borrow, AND, exclusive OR, OR and compare. On each rising clock edge with the execute strobe high, the result goes into the accumulator and five status bits go into the status byte.

Compare computes the same flags as subtract and leaves the accumulator as it was. Add with carry and subtract with borrow take the stored carry bit as their incoming carry or borrow, so multi-byte arithmetic can be chained one byte per strobe. There is no load path. The accumulator gets its value through the logic operations, for example AND with zero and then OR with a value.

Top module: `acc_alu_unit`

## Requirements
- R1: When `rst` is high at a rising clock edge, the accumulator and the status byte both become 0x00. This holds even if `exec_en` is high in the same cycle.
- R2: With `rst` low and `exec_en` low, neither the accumulator nor the status byte changes, whatever the values of `op_sel` and `tmp_opnd`.
- R3: The `op_sel` encoding is: 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 AND, 5 exclusive OR, 6 OR, 7 compare. For codes 0 to 6 the 8-bit result is written to the accumulator on the strobed edge.
- R4: Compare (code 7) updates the status byte exactly as subtract would, and leaves the accumulator unchanged.
- R5: In the status byte, bit 7 is sign, bit 6 is zero, bit 4 is half carry, bit 2 is parity and bit 0 is carry. Bits 5, 3 and 1 always read 0.
- R6: Sign is bit 7 of the 8-bit result. Zero is 1 exactly when the result is 0x00. Parity is 1 when the result has an even number of one bits.
- R7: For add and add with carry, the result is (A + B + c) mod 256. Carry is the carry out of bit 7 and half carry is the carry out of bit 3. Here c is 0 for add and the stored carry bit for add with carry.
- R8: For subtract, subtract with borrow and compare, the result is (A - B - w) mod 256, where w is 0 for subtract and compare and the stored carry bit for subtract with borrow. Carry is 1 when A < B + w (unsigned). Half carry is the carry out of bit 3 of A[3:0] + ~B[3:0] + (1 - w).
- R9: AND, OR and exclusive OR always clear carry. AND sets half carry; OR and exclusive OR clear it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| exec_en | input | 1 | Execute strobe; an edge with this high performs the selected operation |
| op_sel | input | 3 | Operation code (see R3) |
| tmp_opnd | input | 8 | Second operand, from the temporary register |
| acc_q | output | 8 | Accumulator contents |
| flag_q | output | 8 | Status byte (layout in R5) |

## Verification
The hardest state to reach is a particular accumulator value combined with a particular stored carry bit just before an add with carry or subtract with borrow, because there is no direct load. The bench builds each state from operations. AND with 0x00 followed by OR with the target value sets the accumulator. A compare against 0x00 then clears carry, and a compare against 0xFF sets it (for every target below 0xFF), without disturbing the accumulator. This is repeated over a near-exhaustive grid of accumulator and operand values for all eight codes. A reference model in the bench tracks the carry state that actually results, so the 0xFF case is covered correctly.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int DW = 8;
  localparam int NIB = 4;

  // Status byte bit positions
  localparam int FB_SGN = 7;
  localparam int FB_ZRO = 6;
  localparam int FB_HCY = 4;
  localparam int FB_PAR = 2;
  localparam int FB_CRY = 0;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_SBB = 3'd3,
    OP_AND = 3'd4,
    OP_XOR = 3'd5,
    OP_OR  = 3'd6,
    OP_CMP = 3'd7
  } alu_op_e;

  // 1 when the count of ones in v is even
  function automatic logic even_ones(input logic [DW-1:0] v);
    return ~(^v);
  endfunction

  // Carry out of the low nibble for x + y + ci
  function automatic logic low_nib_carry(input logic [NIB-1:0] x,
                                         input logic [NIB-1:0] y,
                                         input logic ci);
    logic [NIB:0] t;
    t = {1'b0, x} + {1'b0, y} + {{NIB{1'b0}}, ci};
    return t[NIB];
  endfunction

  function automatic logic is_logic_op(input logic [2:0] op);
    return (op == OP_AND) || (op == OP_XOR) || (op == OP_OR);
  endfunction

  function automatic logic is_sub_op(input logic [2:0] op);
    return (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
  endfunction

endpackage

// File: rtl/alu_arith.sv
module alu_arith
  import alu_pkg::*;
#(
  parameter int W = DW
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         do_sub,
  input  logic         chain_in,
  input  logic         stored_cy,
  output logic [W-1:0] sum,
  output logic         msb_cout,
  output logic         nib_cout,
  output logic         cy_flag
);
  logic [W-1:0] b_eff;
  logic         cin;
  logic [W:0]   full;

  always_comb begin
    b_eff = do_sub ? ~opb : opb;
    if (do_sub) cin = chain_in ? ~stored_cy : 1'b1;
    else        cin = chain_in ? stored_cy : 1'b0;
    full  = {1'b0, opa} + {1'b0, b_eff} + {{W{1'b0}}, cin};
  end

  assign sum      = full[W-1:0];
  assign msb_cout = full[W];
  assign nib_cout = low_nib_carry(opa[NIB-1:0], b_eff[NIB-1:0], cin);
  // borrow is the inverse of the two's-complement carry
  assign cy_flag  = do_sub ? ~full[W] : full[W];
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int W = DW
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [2:0]   op,
  output logic [W-1:0] res,
  output logic         hcy_flag
);
  always_comb begin
    unique case (op)
      OP_AND:  res = opa & opb;
      OP_XOR:  res = opa ^ opb;
      default: res = opa | opb;
    endcase
    hcy_flag = (op == OP_AND);
  end
endmodule

// File: rtl/alu_flag_pack.sv
module alu_flag_pack
  import alu_pkg::*;
#(
  parameter int W = DW
) (
  input  logic [W-1:0] res,
  input  logic         cy,
  input  logic         hcy,
  output logic [W-1:0] flags
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == FB_SGN) begin : g_s
      assign flags[i] = res[W-1];
    end else if (i == FB_ZRO) begin : g_z
      assign flags[i] = (res == '0);
    end else if (i == FB_HCY) begin : g_h
      assign flags[i] = hcy;
    end else if (i == FB_PAR) begin : g_p
      assign flags[i] = even_ones(res);
    end else if (i == FB_CRY) begin : g_c
      assign flags[i] = cy;
    end else begin : g_pad
      assign flags[i] = 1'b0;
    end
  end
endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
  import alu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       exec_en,
  input  logic [2:0] op_sel,
  input  logic [7:0] tmp_opnd,
  output logic [7:0] acc_q,
  output logic [7:0] flag_q
);
  logic [DW-1:0] arith_sum, logic_res, result_w, flags_w;
  logic          carry_out_w, half_cout_w, arith_cy_w, logic_hcy_w;
  logic          sel_logic_w, sel_sub_w, chain_w, acc_write_w;
  logic          res_cy_w, res_hcy_w;

  assign sel_logic_w = is_logic_op(op_sel);
  assign sel_sub_w   = is_sub_op(op_sel);
  assign chain_w     = (op_sel == OP_ADC) || (op_sel == OP_SBB);
  assign acc_write_w = exec_en && (op_sel != OP_CMP);

  alu_arith #(.W(DW)) u_arith (
    .opa       (acc_q),
    .opb       (tmp_opnd),
    .do_sub    (sel_sub_w),
    .chain_in  (chain_w),
    .stored_cy (flag_q[FB_CRY]),
    .sum       (arith_sum),
    .msb_cout  (carry_out_w),
    .nib_cout  (half_cout_w),
    .cy_flag   (arith_cy_w)
  );

  alu_logic #(.W(DW)) u_logic (
    .opa      (acc_q),
    .opb      (tmp_opnd),
    .op       (op_sel),
    .res      (logic_res),
    .hcy_flag (logic_hcy_w)
  );

  always_comb begin
    if (sel_logic_w) begin
      result_w  = logic_res;
      res_cy_w  = 1'b0;
      res_hcy_w = logic_hcy_w;
    end else begin
      result_w  = arith_sum;
      res_cy_w  = arith_cy_w;
      res_hcy_w = half_cout_w;
    end
  end

  alu_flag_pack #(.W(DW)) u_flags (
    .res   (result_w),
    .cy    (res_cy_w),
    .hcy   (res_hcy_w),
    .flags (flags_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      flag_q <= '0;
    end else if (exec_en) begin
      flag_q <= flags_w;
      if (acc_write_w) acc_q <= result_w;
    end
  end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk (
  input logic       clk,
  input logic       rst,
  input logic       exec_en,
  input logic [2:0] op_sel,
  input logic [7:0] acc_q,
  input logic [7:0] flag_q,
  input logic       carry_out_w
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (acc_q == 8'h00) && (flag_q == 8'h00));

  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !exec_en |=> $stable(acc_q) && $stable(flag_q));

  assert_cmp_keeps_acc_R4: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op_sel == 3'd7) |=> $stable(acc_q));

  assert_pad_bits_zero_R5: assert property (@(posedge clk) disable iff (rst)
    exec_en |=> (flag_q[5] == 1'b0) && (flag_q[3] == 1'b0) && (flag_q[1] == 1'b0));

  // after a logic op the accumulator holds the result, so flags must describe it
  assert_logic_result_flags_R6: assert property (@(posedge clk) disable iff (rst)
    (exec_en && (op_sel == 3'd4 || op_sel == 3'd5 || op_sel == 3'd6)) |=>
      (flag_q[7] == acc_q[7]) && (flag_q[6] == (acc_q == 8'h00)) && (flag_q[2] == ~(^acc_q)));

  assert_add_carry_R7: assert property (@(posedge clk) disable iff (rst)
    (exec_en && op_sel == 3'd0) |=> flag_q[0] == $past(carry_out_w));

  assert_logic_cy_R9: assert property (@(posedge clk) disable iff (rst)
    (exec_en && (op_sel == 3'd4 || op_sel == 3'd5 || op_sel == 3'd6)) |=>
      (flag_q[0] == 1'b0) && (flag_q[4] == (acc_q == acc_q && $past(op_sel) == 3'd4)));
endmodule

bind acc_alu_unit acc_alu_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .exec_en     (exec_en),
  .op_sel      (op_sel),
  .acc_q       (acc_q),
  .flag_q      (flag_q),
  .carry_out_w (carry_out_w)
);

// File: tb/tb_acc_alu_unit.sv
module tb_acc_alu_unit;
  logic       clk = 1'b0;
  logic       rst;
  logic       exec_en;
  logic [2:0] op_sel;
  logic [7:0] tmp_opnd;
  logic [7:0] acc_q, flag_q;

  int total = 0;
  int fails = 0;
  bit done = 0;

  int m_a = 0;
  int m_f = 0;

  always #10 clk = ~clk;

  acc_alu_unit dut (
    .clk(clk), .rst(rst), .exec_en(exec_en), .op_sel(op_sel),
    .tmp_opnd(tmp_opnd), .acc_q(acc_q), .flag_q(flag_q)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic int ones(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return n;
  endfunction

  function automatic int pack(input int r, input int cy, input int hc);
    int f;
    f = 0;
    if (r >= 128) f += 128;
    if (r == 0) f += 64;
    if (hc != 0) f += 16;
    if (ones(r) % 2 == 0) f += 4;
    if (cy != 0) f += 1;
    return f;
  endfunction

  // Bench-side reference model; called at a negedge, consumes one cycle
  task automatic run_op(input int op, input int b);
    int cin, r, cy, hc, na, nf, s;
    string ftag;
    string atag;
    cin = m_f % 2;
    na = m_a;
    if (op <= 1) begin
      s = m_a + b + ((op == 1) ? cin : 0);
      r = s % 256; cy = (s > 255) ? 1 : 0;
      hc = ((m_a % 16) + (b % 16) + ((op == 1) ? cin : 0) > 15) ? 1 : 0;
      na = r; ftag = "R7"; atag = "R3";
    end else if (op == 2 || op == 3 || op == 7) begin
      int w;
      w = (op == 3) ? cin : 0;
      s = m_a - b - w;
      r = (s + 512) % 256; cy = (s < 0) ? 1 : 0;
      hc = ((m_a % 16) + (15 - (b % 16)) + (1 - w) > 15) ? 1 : 0;
      if (op != 7) na = r;
      ftag = (op == 7) ? "R4 R8" : "R8";
      atag = (op == 7) ? "R4" : "R3";
    end else begin
      int t;
      t = 0;
      for (int i = 0; i < 8; i++) begin
        int x, y, z;
        x = (m_a >> i) & 1; y = (b >> i) & 1;
        z = (op == 4) ? (x & y) : (op == 5) ? (x ^ y) : (x | y);
        t += z << i;
      end
      r = t; cy = 0; hc = (op == 4) ? 1 : 0;
      na = r; ftag = "R9"; atag = "R3";
    end
    nf = pack(r, cy, hc);
    op_sel = op[2:0]; tmp_opnd = b[7:0]; exec_en = 1'b1;
    @(negedge clk);
    exec_en = 1'b0;
    check({atag, " acc"}, int'(acc_q), na);
    check({ftag, " R6 flags"}, int'(flag_q), nf);
    check("R5 pad bits", int'(flag_q) & 8'h2A, 0);
    m_a = na; m_f = nf;
  endtask

  task automatic set_acc(input int v);
    run_op(4, 0);
    run_op(6, v);
  endtask

  initial begin
    rst = 1'b1; exec_en = 1'b0; op_sel = 3'd0; tmp_opnd = 8'h00;
    @(negedge clk); @(negedge clk);
    check("R1 reset acc", int'(acc_q), 0);
    check("R1 reset flags", int'(flag_q), 0);
    rst = 1'b0;

    // directed corners
    set_acc(8'h80); run_op(0, 8'h80);   // 0x00, carry, zero
    set_acc(8'h0F); run_op(0, 8'h01);   // half carry
    set_acc(8'h00); run_op(2, 8'h01);   // borrow, 0xFF
    run_op(3, 8'h00);                   // SBB with borrow in
    set_acc(8'hFF); run_op(1, 8'h00);   // ADC with carry clear
    set_acc(8'h35); run_op(7, 8'h35);   // compare equal

    // R2: idle strobe-low cycles with varied inputs
    set_acc(8'hA5); run_op(7, 8'hF0);
    for (int k = 0; k < 8; k++) begin
      op_sel = k[2:0]; tmp_opnd = 8'(k * 29 + 3);
      @(negedge clk);
      check("R2 idle acc", int'(acc_q), m_a);
      check("R2 idle flags", int'(flag_q), m_f);
    end

    // R1: reset wins over strobe
    rst = 1'b1; exec_en = 1'b1; op_sel = 3'd6; tmp_opnd = 8'hFF;
    @(negedge clk);
    rst = 1'b0; exec_en = 1'b0;
    check("R1 reset priority acc", int'(acc_q), 0);
    check("R1 reset priority flags", int'(flag_q), 0);
    m_a = 0; m_f = 0;

    // near-exhaustive sweep
    for (int a = 0; a < 256; a += 3) begin
      for (int k = 0; k < 34; k++) begin
        int b;
        b = (k == 32) ? 0 : (k == 33) ? 255 : (k * 37 + 5) % 256;
        for (int op = 0; op < 8; op++) begin
          if (op == 1 || op == 3) begin
            for (int c = 0; c < 2; c++) begin
              set_acc(a);
              run_op(7, c ? 255 : 0);
              run_op(op, b);
            end
          end else begin
            set_acc(a);
            run_op(op, b);
          end
        end
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule